// File: doc/BRIEF.md
# Parallel FPGA Configuration Host

This block is the external host that loads a bitstream into a target FPGA through a passive parallel configuration port. A single `start` pulse makes it drive the active-low configuration request low for a fixed number of system clocks. It then waits for the target's active-low status line to fall and rise again, and streams bitstream words from an upstream valid/ready source, one word per generated DCLK cycle. After configuration-done rises it supplies exactly two further DCLK falling edges. When initialization-done is in use, it also waits for that pin before reporting user mode.

DCLK runs at a fixed division of the system clock, with a clock-to-data ratio of 1. A new word goes onto the bus only while DCLK is low, so each word is set up a full half period before the rising edge and held until after the falling edge. The three target inputs pass through a synchronizer. Every wait has a bound. A failure leaves a two-bit error code, releases the port and returns the host to idle, so the next `start` retries.

Top module: `pcfg_host`

## Requirements
- R1: During and right after reset, `cfg_req_n` is 1, `dclk` is 0, and `s_ready`, `busy`, `user_mode` and `err` are 0. `user_mode` and `err` are never 1 together.
- R2: Each accepted `start` drives `cfg_req_n` low for exactly `REQ_CYC` consecutive system clocks. `dclk` stays low while `cfg_req_n` is low.
- R3: No DCLK rising edge occurs before the synchronized status has been seen low and then high. If either wait lasts `STATUS_TMO` clocks, the host stops with `err_code` = 1.
- R4: Words reach `cfg_data` in stream order, one per DCLK period. `cfg_data` changes only while `dclk` is low. The target samples each word on exactly one rising edge.
- R5: `s_ready` is 1 only during streaming, while `dclk` is low and no word is held. It stays 0 once the last-marked word is taken or done is seen.
- R6: After done rises, exactly two DCLK falling edges follow. `dclk` then stays low and, once the target has finished, `user_mode` becomes 1 with `err_code` = 0.
- R7: If status goes low during streaming, the host stops with `err_code` = 2. It returns to idle with `cfg_req_n` = 1, `dclk` = 0 and `s_ready` = 0.
- R8: After the last-marked word, the host gives at most `DONE_TMO` extra DCLK rising edges while waiting for done. If done has not arrived by then, it stops with `err_code` = 3.
- R9: With `USE_INIT` set, `user_mode` rises only after initialization-done is high. If that does not happen within `STATUS_TMO` clocks, the host stops with `err_code` = 3.
- R10: `start` is ignored while `busy`. It is accepted in idle or user mode, where it clears `err`, `err_code` and `user_mode`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a configuration run |
| s_data | input | BUS_W | Bitstream word from the source |
| s_valid | input | 1 | Source word valid |
| s_last | input | 1 | Marks the final bitstream word |
| s_ready | output | 1 | Host takes the word this cycle |
| cfg_req_n | output | 1 | Active-low configuration request to the target |
| dclk | output | 1 | Configuration clock to the target |
| cfg_data | output | BUS_W | Configuration data bus to the target |
| tgt_status_n | input | 1 | Target active-low status |
| tgt_done | input | 1 | Target configuration-done |
| tgt_init_done | input | 1 | Target initialization-done |
| busy | output | 1 | A run is in progress |
| user_mode | output | 1 | Target configured and in user mode |
| err | output | 1 | Last run failed |
| err_code | output | 2 | 1 status timeout, 2 status lost, 3 target did not finish |

## Verification
The bench sweeps word counts, source gaps and done latencies up to and just past the drain limit. It counts falling edges after done. A host that stopped one edge early or kept DCLK running would show a count other than two. It also drops status in the middle of a stream, never releases status or never pulls it low, withholds initialization-done, and pulses `start` while busy. A design that missed any of these would clock data into a target that is not ready, hang, report user mode too early, or start a second request.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT_LO,
        ST_WAIT_HI,
        ST_XFER,
        ST_INIT,
        ST_USER
    } pcfg_state_e;

    typedef enum logic [1:0] {
        E_NONE        = 2'd0,
        E_STATUS_TMO  = 2'd1,
        E_STATUS_LOST = 2'd2,
        E_NO_FINISH   = 2'd3
    } pcfg_err_e;

endpackage

// File: rtl/pcfg_sync.sv
module pcfg_sync #(
    parameter int           W      = 1,
    parameter int           STAGES = 2,
    parameter logic [W-1:0] RST    = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] pipe_d, pipe_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb pipe_d = d;
        end else begin : g_many
            always_comb pipe_d = {pipe_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST}};
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/pcfg_tick.sv
module pcfg_tick #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = run && (cnt_q == CW'(DIV - 1));
        cnt_d = cnt_q;
        if (!run || tick) cnt_d = '0;
        else              cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pcfg_host.sv
module pcfg_host
    import pcfg_pkg::*;
#(
    parameter int BUS_W       = 16,
    parameter int DIV         = 4,
    parameter int SYNC_STAGES = 2,
    parameter int REQ_CYC     = 16,
    parameter int STATUS_TMO  = 1000,
    parameter int DONE_TMO    = 64,
    parameter bit USE_INIT    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [BUS_W-1:0] s_data,
    input  logic             s_valid,
    input  logic             s_last,
    output logic             s_ready,
    output logic             cfg_req_n,
    output logic             dclk,
    output logic [BUS_W-1:0] cfg_data,
    input  logic             tgt_status_n,
    input  logic             tgt_done,
    input  logic             tgt_init_done,
    output logic             busy,
    output logic             user_mode,
    output logic             err,
    output logic [1:0]       err_code
);
    localparam int MAX_A = (REQ_CYC > STATUS_TMO) ? REQ_CYC : STATUS_TMO;
    localparam int MAX_B = (MAX_A > DONE_TMO) ? MAX_A : DONE_TMO;
    localparam int CNT_W = $clog2(MAX_B + 1);

    typedef struct packed {
        pcfg_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic             dclk;
        logic             have;
        logic             last;
        logic             falls;
        logic [BUS_W-1:0] data;
        logic             user;
        logic             err;
        pcfg_err_e        code;
    } host_regs_t;

    host_regs_t r_q, r_d;

    logic [2:0] tgt_sync;
    logic       status_s, done_s, init_s;
    logic       run, tick;

    pcfg_sync #(
        .W      (3),
        .STAGES (SYNC_STAGES),
        .RST    (3'b001)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({tgt_init_done, tgt_done, tgt_status_n}),
        .q     (tgt_sync)
    );

    assign status_s = tgt_sync[0];
    assign done_s   = tgt_sync[1];
    assign init_s   = tgt_sync[2];

    assign run = (r_q.st == ST_XFER) && (r_q.have || r_q.last || r_q.dclk || done_s);

    pcfg_tick #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .tick  (tick)
    );

    always_comb begin
        r_d     = r_q;
        s_ready = (r_q.st == ST_XFER) && !r_q.dclk && !r_q.have && !r_q.last && !done_s && status_s;

        case (r_q.st)
            ST_IDLE, ST_USER: begin
                if (start) begin
                    r_d.st   = ST_REQ;
                    r_d.cnt  = '0;
                    r_d.err  = 1'b0;
                    r_d.code = E_NONE;
                    r_d.user = 1'b0;
                end
            end

            ST_REQ: begin
                if (r_q.cnt == CNT_W'(REQ_CYC - 1)) begin
                    r_d.st  = ST_WAIT_LO;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end

            ST_WAIT_LO, ST_WAIT_HI: begin
                if ((r_q.st == ST_WAIT_LO) && !status_s) begin
                    r_d.st  = ST_WAIT_HI;
                    r_d.cnt = '0;
                end else if ((r_q.st == ST_WAIT_HI) && status_s) begin
                    r_d.st    = ST_XFER;
                    r_d.cnt   = '0;
                    r_d.dclk  = 1'b0;
                    r_d.have  = 1'b0;
                    r_d.last  = 1'b0;
                    r_d.falls = 1'b0;
                end else if (r_q.cnt == CNT_W'(STATUS_TMO - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.err  = 1'b1;
                    r_d.code = E_STATUS_TMO;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end

            ST_XFER: begin
                if (!status_s) begin
                    r_d.st   = ST_IDLE;
                    r_d.dclk = 1'b0;
                    r_d.have = 1'b0;
                    r_d.err  = 1'b1;
                    r_d.code = E_STATUS_LOST;
                end else begin
                    if (s_valid && s_ready) begin
                        r_d.data = s_data;
                        r_d.have = 1'b1;
                        r_d.last = s_last;
                    end
                    if (tick) begin
                        if (!r_q.dclk) begin
                            if (r_q.have || done_s) begin
                                r_d.dclk = 1'b1;
                            end else if (r_q.cnt == CNT_W'(DONE_TMO)) begin
                                r_d.st   = ST_IDLE;
                                r_d.err  = 1'b1;
                                r_d.code = E_NO_FINISH;
                            end else begin
                                r_d.dclk = 1'b1;
                                r_d.cnt  = r_q.cnt + 1'b1;
                            end
                        end else begin
                            r_d.dclk = 1'b0;
                            r_d.have = 1'b0;
                            if (done_s) begin
                                if (r_q.falls) begin
                                    r_d.cnt  = '0;
                                    r_d.st   = USE_INIT ? ST_INIT : ST_USER;
                                    r_d.user = !USE_INIT;
                                end else begin
                                    r_d.falls = 1'b1;
                                end
                            end
                        end
                    end
                end
            end

            ST_INIT: begin
                if (init_s) begin
                    r_d.st   = ST_USER;
                    r_d.user = 1'b1;
                end else if (r_q.cnt == CNT_W'(STATUS_TMO - 1)) begin
                    r_d.st   = ST_IDLE;
                    r_d.err  = 1'b1;
                    r_d.code = E_NO_FINISH;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_IDLE;
            r_q.code  <= E_NONE;
        end else begin
            r_q <= r_d;
        end
    end

    assign cfg_req_n = (r_q.st != ST_REQ);
    assign dclk      = r_q.dclk;
    assign cfg_data  = r_q.data;
    assign busy      = (r_q.st != ST_IDLE) && (r_q.st != ST_USER);
    assign user_mode = r_q.user;
    assign err       = r_q.err;
    assign err_code  = r_q.code;
endmodule

// File: rtl/pcfg_host_chk.sv
module pcfg_host_chk #(
    parameter int BUS_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_ready,
    input logic             cfg_req_n,
    input logic             dclk,
    input logic [BUS_W-1:0] cfg_data,
    input logic             tgt_done,
    input logic             busy,
    input logic             user_mode,
    input logic             err
);
    // R1: success and failure are never reported together
    p_excl_flags_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(user_mode && err));

    // R2: the configuration clock is quiet while the request is asserted
    p_no_clk_in_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_req_n |-> !dclk);

    // R4: the data bus never moves while DCLK is high
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dclk |-> $stable(cfg_data));

    // R5: the source is only taken while DCLK is low during a run
    p_ready_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!dclk && busy));

    // R6: user mode starts with done high and DCLK parked low
    p_user_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(user_mode) |-> (tgt_done && !dclk));

    // R7: a failure leaves the port released and the host idle
    p_err_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !dclk && cfg_req_n && !s_ready));
endmodule

bind pcfg_host pcfg_host_chk #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_ready   (s_ready),
    .cfg_req_n (cfg_req_n),
    .dclk      (dclk),
    .cfg_data  (cfg_data),
    .tgt_done  (tgt_done),
    .busy      (busy),
    .user_mode (user_mode),
    .err       (err)
);

// File: tb/pcfg_host_tb_top.sv
module pcfg_host_tb_top;
    localparam int BW   = 16;
    localparam int DIVB = 4;
    localparam int REQB = 5;
    localparam int STMO = 20;
    localparam int DTMO = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [BW-1:0] s_data = '0;
    logic          s_valid = 1'b0;
    logic          s_last = 1'b0;
    logic          s_ready, cfg_req_n, dclk, busy, user_mode, err;
    logic [BW-1:0] cfg_data;
    logic [1:0]    err_code;
    logic          tgt_status_n = 1'b1;
    logic          tgt_done = 1'b0;
    logic          tgt_init = 1'b0;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    // target model controls, written only by the main sequence
    int  t_sdly = 4;
    int  t_done_lat = 0;
    int  t_init_lat = 2;
    int  t_drop_at = -1;
    int  nwords = 1;
    bit  t_hold_hi = 1'b0;

    // target model observations, written only by the model
    int  req_falls = 0, req_low_len = 0, rises = 0, dfalls = 0;
    int  early_rise = 0, bad_ready = 0, rel_cnt = -1, init_cnt = -1;
    bit  user_pre = 1'b1, req_prev = 1'b1, dclk_prev = 1'b0;
    logic [BW-1:0] got [64];

    always #4 clk = ~clk;

    pcfg_host #(
        .BUS_W(BW), .DIV(DIVB), .SYNC_STAGES(2), .REQ_CYC(REQB),
        .STATUS_TMO(STMO), .DONE_TMO(DTMO), .USE_INIT(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start),
        .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
        .cfg_req_n(cfg_req_n), .dclk(dclk), .cfg_data(cfg_data),
        .tgt_status_n(tgt_status_n), .tgt_done(tgt_done), .tgt_init_done(tgt_init),
        .busy(busy), .user_mode(user_mode), .err(err), .err_code(err_code)
    );

    function automatic logic [BW-1:0] word_of(int i);
        return BW'((i + 1) * 32'h1357) ^ BW'(16'hA0A0);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (req_prev && !cfg_req_n) begin
                req_falls++;
                req_low_len = 0; rises = 0; dfalls = 0; early_rise = 0; bad_ready = 0;
                rel_cnt = -1; init_cnt = -1; user_pre = 1'b1;
                tgt_status_n = t_hold_hi; tgt_done = 1'b0; tgt_init = 1'b0;
            end
            if (!cfg_req_n) req_low_len++;
            if (!req_prev && cfg_req_n && !t_hold_hi) rel_cnt = t_sdly;
            else if (rel_cnt == 0) begin tgt_status_n = 1'b1; rel_cnt = -1; end
            else if (rel_cnt > 0) rel_cnt--;
            if (!dclk_prev && dclk) begin
                if (!tgt_status_n) early_rise++;
                if (rises < 64) got[rises] = cfg_data;
                rises++;
                if (t_drop_at >= 0 && rises == t_drop_at) tgt_status_n = 1'b0;
                if (t_done_lat >= 0 && rises == nwords + t_done_lat) tgt_done = 1'b1;
            end
            if (init_cnt == 0) begin user_pre = user_mode; tgt_init = 1'b1; init_cnt = -1; end
            else if (init_cnt > 0) init_cnt--;
            if (dclk_prev && !dclk && tgt_done) begin
                dfalls++;
                if (dfalls == 2 && t_init_lat >= 0) init_cnt = t_init_lat;
            end
            if (s_ready && (dclk || !busy)) bad_ready++;
            req_prev = cfg_req_n;
            dclk_prev = dclk;
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        cycles++;
    endtask

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic feed(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            if (gap && (i % 2 == 1)) begin s_valid = 1'b0; step(); step(); end
            s_data = word_of(i); s_last = (i == n - 1); s_valid = 1'b1;
            for (int k = 0; k < 400; k++) begin
                if (err) break;
                if (s_ready) begin step(); break; end
                step();
            end
            s_valid = 1'b0; s_last = 1'b0;
            if (err) break;
        end
    endtask

    task automatic run_case(input int nw, input int sdly, input int dlat, input int ilat,
                            input int drop, input bit gap, input bit hold_hi, input bit start_mid);
        int  exp_code;
        int  falls0;
        bit  done_flag;
        nwords = nw; t_sdly = sdly; t_done_lat = (dlat > DTMO) ? -1 : dlat;
        t_init_lat = ilat; t_drop_at = drop; t_hold_hi = hold_hi;
        if (hold_hi || sdly < 0)      exp_code = 1;
        else if (drop >= 0)           exp_code = 2;
        else if (dlat > DTMO || ilat < 0) exp_code = 3;
        else                          exp_code = 0;
        falls0 = req_falls;
        start = 1'b1; step(); start = 1'b0; step();
        done_flag = 1'b0;
        fork
            feed(nw, gap);
            begin
                bit pulsed = 1'b0;
                for (int c = 0; c < 3000; c++) begin
                    if (user_mode || err) begin done_flag = 1'b1; break; end
                    if (start_mid && !pulsed && rises == 2) begin
                        start = 1'b1; step(); start = 1'b0; pulsed = 1'b1;
                    end else step();
                end
            end
        join
        if (!done_flag) chk("watchdog", "run did not finish", 0, 1);
        for (int c = 0; c < 12; c++) step();
        chk("R2", "request low cycles", req_low_len, REQB);
        chk("R10", "request pulses per run", req_falls - falls0, 1);
        chk("R3", "DCLK rises while status low", early_rise, 0);
        chk("R5", "ready while DCLK high or idle", bad_ready, 0);
        chk("R1", "user and err together", user_mode && err, 0);
        if (exp_code == 0) begin
            for (int i = 0; i < nw; i++) chk("R4", "word value", got[i], word_of(i));
            chk("R4", "rising edges", rises, nw + dlat + 1);
            chk("R6", "falling edges after done", dfalls, 2);
            chk("R6", "user_mode", user_mode, 1);
            chk("R6", "dclk parked", dclk, 0);
            chk("R6", "err_code", err_code, 0);
            chk("R9", "user_mode before init", user_pre, 0);
        end else begin
            chk(exp_code == 1 ? "R3" : exp_code == 2 ? "R7" : (ilat < 0 ? "R9" : "R8"),
                "err_code", err_code, exp_code);
            chk("R7", "err flag", err, 1);
            chk("R7", "idle port", {busy, dclk, cfg_req_n, s_ready}, 4'b0010);
            if (exp_code == 1) chk("R3", "no DCLK rises", rises, 0);
            if (exp_code == 2) chk("R7", "rises before stop", rises, drop);
            if (exp_code == 3 && ilat >= 0) chk("R8", "drain rises", rises, nw + DTMO);
        end
    endtask

    initial begin
        for (int c = 0; c < 4; c++) step();
        chk("R1", "reset outputs", {cfg_req_n, dclk, s_ready, busy, user_mode, err},
            6'b100000);
        rst_n = 1'b1;
        step();
        chk("R1", "after reset outputs", {cfg_req_n, dclk, s_ready, busy, user_mode, err},
            6'b100000);
        // sweep of word counts, source gaps and done latencies
        for (int nw = 1; nw <= 5; nw += 2)
            for (int dl = 0; dl <= DTMO; dl++)
                run_case(nw, 3 + dl, dl, 1 + (nw % 2), -1, bit'((nw + dl) % 2), 1'b0, 1'b0);
        run_case(4, 2, DTMO + 1, 2, -1, 1'b0, 1'b0, 1'b0);   // R8 done never rises
        run_case(4, 2, 0, 2, 2, 1'b0, 1'b0, 1'b0);           // R7 status drops
        run_case(3, -1, 0, 2, -1, 1'b0, 1'b0, 1'b0);         // R3 status never released
        run_case(3, 2, 0, 2, -1, 1'b0, 1'b1, 1'b0);          // R3 status never pulled low
        run_case(3, 2, 1, -1, -1, 1'b0, 1'b0, 1'b0);         // R9 init never rises
        run_case(5, 2, 1, 1, -1, 1'b1, 1'b0, 1'b1);          // R10 start while busy
        run_case(2, 1, 0, 0, -1, 1'b0, 1'b0, 1'b0);          // R10 retry from user mode
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule